// File: doc/BRIEF.md
# Vectored Interrupt Controller with Priority Daisy-Chain

This block collects sixteen interrupt sources into one active-low request line for the processor. Sources 0 to 7 are the on-chip sources and 8 to 15 the external lines. Every source has its own sticky pending bit, which is set by a one-cycle pulse on its set input. A per-source enable vector decides which pending bits take part in the request and in arbitration. When the processor runs an interrupt acknowledge cycle, it drives the acknowledge strobe and the data strobe low together. The block then latches the highest-numbered enabled pending source. It drives an 8-bit vector, made of a configurable upper nibble and the source number, onto the data bus, and after that it asserts the transfer acknowledge. The serviced pending bit clears when the processor ends the cycle.

Several of these blocks can share one interrupt level by being wired into a priority chain. A low enable-in means that no device higher in the chain is requesting. The top device ties enable-in low. Enable-out feeds the next device's enable-in. It is low only when enable-in is low and this block has no enabled pending source. Only the device that sees a low enable-in and has a request answers an acknowledge cycle. Every other device keeps its drivers off until that cycle ends. Tri-state pins are modelled as value plus output-enable pairs.

Top module: `irq_vec_chain`

## Requirements
- R1: During and right after synchronous reset, all pending bits are clear, `irq_n_o` is 1, `data_oe_o` and `dtack_oe_o` are 0, and `ieo_n_o` equals `iei_n_i`.
- R2: A 1 on `src_set_i[k]` at a clock edge sets pending bit k, and the bit stays set until it is serviced. `irq_n_o` is 0 exactly when some pending bit has its `src_en_i` bit at 1. The change is visible after the edge that samples the set pulse.
- R3: A pending source whose enable bit is 0 neither requests nor wins arbitration, but it stays pending. Setting its enable bit to 1 later makes it request.
- R4: When several enabled sources are pending, the highest source number wins.
- R5: An acknowledge cycle is active while `iack_n_i` and `ds_n_i` are both 0. At the first edge that samples an active cycle with `iei_n_i`=0 and a request present, the winner is latched. After that edge `data_oe_o`=1 and `data_o` = {`vec_base_i`, 4-bit winner number}. One edge later `dtack_oe_o`=1 with `dtack_n_o`=0.
- R6: At the edge that samples either strobe high while the block is serving, the block floats the data bus and drives `dtack_n_o`=1 with `dtack_oe_o`=1 for exactly one cycle. After the next edge `dtack_oe_o`=0.
- R7: The winner's pending bit clears at the edge that ends the cycle. `irq_n_o` stays 0 if other enabled sources are still pending.
- R8: If `iei_n_i` is 1 when an acknowledge cycle starts, the block drives neither the data bus nor the transfer acknowledge for the whole cycle. This holds even if `iei_n_i` falls before the strobes rise.
- R9: An acknowledge cycle that starts with no enabled pending source gets no bus drive and no transfer acknowledge.
- R10: `ieo_n_o` = `iei_n_i` OR (some enabled pending source), combinationally.
- R11: If the winner's set pulse arrives at the same edge that ends its cycle, the set takes priority and the bit stays pending.
- R12: The vector latched at the start of a cycle does not change during that cycle, even if a higher source becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | 16 | Per-source pending set pulses |
| src_en_i | input | 16 | Per-source enables |
| vec_base_i | input | 4 | Upper nibble of the vector |
| iack_n_i | input | 1 | Interrupt acknowledge strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| iei_n_i | input | 1 | Chain enable in, low = no higher device requesting |
| irq_n_o | output | 1 | Interrupt request, active low |
| ieo_n_o | output | 1 | Chain enable out |
| data_o | output | 8 | Vector value |
| data_oe_o | output | 1 | Data bus drive enable |
| dtack_n_o | output | 1 | Transfer acknowledge value, active low |
| dtack_oe_o | output | 1 | Transfer acknowledge drive enable |

## Verification
The request line and the pending state respond one edge after a set pulse. The vector appears one edge after the strobes are sampled low, and the transfer acknowledge follows one edge later. Release starts one edge after a strobe is sampled high, and the acknowledge floats on the edge after that. Enable-out is combinational and is checked one time step after `iei_n_i` is driven. The bench drives inputs just after a rising edge and samples two time units after each edge, so every check looks at the value that the edge-by-edge count above predicts. A bench model of the pending bits, the enables and the priority order supplies the expected values.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_ACK,
        ST_REL,
        ST_PASS
    } ack_st_e;

    typedef struct packed {
        logic data_oe;
        logic dtack_oe;
        logic dtack_n;
    } bus_drv_t;

    function automatic bus_drv_t drive_of(input ack_st_e st);
        bus_drv_t d;
        d = '{data_oe: 1'b0, dtack_oe: 1'b0, dtack_n: 1'b1};
        case (st)
            ST_VEC: d.data_oe = 1'b1;
            ST_ACK: begin
                d.data_oe  = 1'b1;
                d.dtack_oe = 1'b1;
                d.dtack_n  = 1'b0;
            end
            ST_REL: d.dtack_oe = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_SRC = 16,
    parameter int ID_W  = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] set_i,
    input  logic             clr_en_i,
    input  logic [ID_W-1:0]  clr_idx_i,
    output logic [N_SRC-1:0] pend_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_en_i && (clr_idx_i == ID_W'(g)))
                pend_o[g] <= 1'b0;
        end

        AST_SET_STICKY: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> pend_o[g]); // R11
    end

    AST_CLEAR_WINNER: assert property (@(posedge clk) disable iff (rst)
        (clr_en_i && !set_i[clr_idx_i]) |=> !pend_o[$past(clr_idx_i)]); // R7

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N_SRC = 16,
    parameter int ID_W  = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    output logic             any_o,
    output logic [ID_W-1:0]  idx_o
);

    logic [N_SRC-1:0] live;

    always_comb begin
        live  = pend_i & en_i;
        any_o = |live;
        idx_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (live[i])
                idx_o = ID_W'(i);
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_vec_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int VEC_W  = 8,
    parameter int BASE_W = VEC_W - ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iack_n_i,
    input  logic              ds_n_i,
    input  logic              iei_n_i,
    input  logic              any_req_i,
    input  logic [ID_W-1:0]   win_idx_i,
    input  logic [BASE_W-1:0] base_i,
    output bus_drv_t          drv_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              clr_en_o,
    output logic [ID_W-1:0]   clr_idx_o
);

    ack_st_e           st_q, st_d;
    logic [ID_W-1:0]   win_q;
    logic [VEC_W-1:0]  vec_q;
    logic              cyc_on;
    logic              grab;

    assign cyc_on = !iack_n_i && !ds_n_i;
    assign grab   = (st_q == ST_IDLE) && cyc_on && !iei_n_i && any_req_i;

    always_comb begin
        st_d     = st_q;
        clr_en_o = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cyc_on)
                    st_d = grab ? ST_VEC : ST_PASS;
            end
            ST_VEC, ST_ACK: begin
                if (!cyc_on) begin
                    st_d     = ST_REL;
                    clr_en_o = 1'b1;
                end else begin
                    st_d = ST_ACK;
                end
            end
            ST_REL:  st_d = ST_IDLE;
            ST_PASS: if (!cyc_on) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
            vec_q <= '0;
        end else begin
            st_q <= st_d;
            if (grab) begin
                win_q <= win_idx_i;
                vec_q <= {base_i, win_idx_i};
            end
        end
    end

    assign clr_idx_o = win_q;
    assign drv_o     = drive_of(st_q);
    assign vec_o     = drv_o.data_oe ? vec_q : '0;

    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && cyc_on && iei_n_i) |=> !drv_o.data_oe); // R8

    AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PASS && cyc_on) |=> (st_q == ST_PASS)); // R8

    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACK) |-> $stable(vec_q)); // R12

endmodule

// File: rtl/irq_vec_chain.sv
module irq_vec_chain
    import irq_vec_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int ID_W   = $clog2(N_SRC),
    parameter int VEC_W  = 8,
    parameter int BASE_W = VEC_W - ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_set_i,
    input  logic [N_SRC-1:0]  src_en_i,
    input  logic [BASE_W-1:0] vec_base_i,
    input  logic              iack_n_i,
    input  logic              ds_n_i,
    input  logic              iei_n_i,
    output logic              irq_n_o,
    output logic              ieo_n_o,
    output logic [VEC_W-1:0]  data_o,
    output logic              data_oe_o,
    output logic              dtack_n_o,
    output logic              dtack_oe_o
);

    logic [N_SRC-1:0] pend;
    logic             any_req;
    logic [ID_W-1:0]  win_idx;
    logic             clr_en;
    logic [ID_W-1:0]  clr_idx;
    bus_drv_t         drv;

    irq_pend_bank #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .set_i     (src_set_i),
        .clr_en_i  (clr_en),
        .clr_idx_i (clr_idx),
        .pend_o    (pend)
    );

    irq_prio_arb #(.N_SRC(N_SRC), .ID_W(ID_W)) u_arb (
        .pend_i (pend),
        .en_i   (src_en_i),
        .any_o  (any_req),
        .idx_o  (win_idx)
    );

    irq_ack_fsm #(.ID_W(ID_W), .VEC_W(VEC_W), .BASE_W(BASE_W)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .iack_n_i  (iack_n_i),
        .ds_n_i    (ds_n_i),
        .iei_n_i   (iei_n_i),
        .any_req_i (any_req),
        .win_idx_i (win_idx),
        .base_i    (vec_base_i),
        .drv_o     (drv),
        .vec_o     (data_o),
        .clr_en_o  (clr_en),
        .clr_idx_o (clr_idx)
    );

    assign irq_n_o    = !any_req;
    assign ieo_n_o    = iei_n_i || any_req;
    assign data_oe_o  = drv.data_oe;
    assign dtack_oe_o = drv.dtack_oe;
    assign dtack_n_o  = drv.dtack_n;

    AST_ACK_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        (dtack_oe_o && !dtack_n_o) |-> data_oe_o); // R5

    AST_DATA_LEADS_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n_o) |-> $past(data_oe_o)); // R5

    AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (dtack_oe_o && dtack_n_o) |=> !dtack_oe_o); // R6

    AST_CHAIN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> ieo_n_o); // R10

endmodule

// File: tb/irq_vec_chain_tb_top.sv
module irq_vec_chain_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] src_set_i;
    logic [15:0] src_en_i;
    logic [3:0]  vec_base_i;
    logic        iack_n_i, ds_n_i, iei_n_i;
    logic        irq_n_o, ieo_n_o, data_oe_o, dtack_n_o, dtack_oe_o;
    logic [7:0]  data_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] m_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_chain dut_i (
        .clk(clk), .rst(rst), .src_set_i(src_set_i), .src_en_i(src_en_i),
        .vec_base_i(vec_base_i), .iack_n_i(iack_n_i), .ds_n_i(ds_n_i),
        .iei_n_i(iei_n_i), .irq_n_o(irq_n_o), .ieo_n_o(ieo_n_o),
        .data_o(data_o), .data_oe_o(data_oe_o), .dtack_n_o(dtack_n_o),
        .dtack_oe_o(dtack_oe_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] top_src(input logic [15:0] v);
        logic [3:0] r = '0;
        for (int i = 0; i < 16; i++) if (v[i]) r = 4'(i);
        return r;
    endfunction

    function automatic logic want_irq();
        return |(m_pend & src_en_i);
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check_req_lines(input string req);
        #1;
        check({req, " irq"}, irq_n_o, !want_irq());
        check({req, " ieo"}, ieo_n_o, iei_n_i | want_irq());
    endtask

    task automatic pulse_set(input logic [15:0] m);
        src_set_i = m;
        step();
        src_set_i = '0;
        m_pend |= m;
        check_req_lines("R2");
    endtask

    task automatic ack_cycle(input bit end_by_ds, input logic [15:0] mid_set,
                             input bit set_at_end, input bit drop_iei);
        logic       serve;
        logic [3:0] win;
        logic [7:0] vec;
        serve = !iei_n_i && want_irq();
        win   = top_src(m_pend & src_en_i);
        vec   = {vec_base_i, win};
        iack_n_i = 1'b0;
        ds_n_i   = 1'b0;
        step();
        check(serve ? "R5 data_oe" : "R8/R9 data_oe", data_oe_o, serve);
        if (serve) check("R4/R5 vector", data_o, vec);
        check("R5 no early dtack", dtack_oe_o, 1'b0);
        if (drop_iei) iei_n_i = 1'b0;
        src_set_i = mid_set;
        step();
        src_set_i = '0;
        m_pend |= mid_set;
        check(serve ? "R5 data held" : "R8/R9 quiet", data_oe_o, serve);
        if (serve) check("R12 vector stable", data_o, vec);
        check(serve ? "R5 dtack_oe" : "R8/R9 dtack_oe", dtack_oe_o, serve);
        check("R5 dtack_n", dtack_n_o, !serve);
        if (end_by_ds) ds_n_i = 1'b1; else iack_n_i = 1'b1;
        if (set_at_end) src_set_i = 16'(1) << win;
        step();
        src_set_i = '0;
        if (serve && !set_at_end) m_pend[win] = 1'b0;
        check("R6 data float", data_oe_o, 1'b0);
        check("R6 dtack high driven", dtack_oe_o, serve);
        check("R6 dtack_n", dtack_n_o, 1'b1);
        check("R7/R11 irq after end", irq_n_o, !want_irq());
        iack_n_i = 1'b1;
        ds_n_i   = 1'b1;
        step();
        check("R6 dtack floated", dtack_oe_o, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        src_set_i = '0;
        src_en_i = 16'hffff;
        vec_base_i = 4'hA;
        iack_n_i = 1'b1;
        ds_n_i = 1'b1;
        iei_n_i = 1'b0;
        repeat (3) step();
        check("R1 irq", irq_n_o, 1'b1);
        check("R1 ieo", ieo_n_o, 1'b0);
        check("R1 data_oe", data_oe_o, 1'b0);
        check("R1 dtack_oe", dtack_oe_o, 1'b0);
        rst = 1'b0;
        step();
        check("R1 irq after reset", irq_n_o, 1'b1);

        // R2, R4, R5, R7: two sources, highest first
        pulse_set(16'h0104);
        ack_cycle(1'b1, '0, 1'b0, 1'b0);
        ack_cycle(1'b0, '0, 1'b0, 1'b0);
        check("R7 all served", irq_n_o, 1'b1);

        // R3: masked source stays pending and is not served (R9)
        src_en_i = ~16'h0020;
        pulse_set(16'h0020);
        ack_cycle(1'b1, '0, 1'b0, 1'b0);
        src_en_i = 16'hffff;
        check_req_lines("R3 re-enabled");
        ack_cycle(1'b0, '0, 1'b0, 1'b0);

        // R8: blocked by chain, enable-in drops mid cycle
        pulse_set(16'h8000);
        iei_n_i = 1'b1;
        check_req_lines("R10 blocked");
        ack_cycle(1'b1, '0, 1'b0, 1'b1);
        check_req_lines("R10 open");

        // R12: higher source arrives mid cycle; R11: set at end
        pulse_set(16'h0001);
        ack_cycle(1'b1, 16'h4000, 1'b0, 1'b0);
        ack_cycle(1'b0, '0, 1'b1, 1'b0);
        ack_cycle(1'b1, '0, 1'b0, 1'b0);
        ack_cycle(1'b1, '0, 1'b0, 1'b0);

        // R9: nothing pending at all
        check("R9 idle irq", irq_n_o, !want_irq());
        ack_cycle(1'b0, '0, 1'b0, 1'b0);

        for (int it = 0; it < 60; it++) begin
            pulse_set(16'($urandom()) & 16'($urandom()));
            src_en_i   = 16'($urandom()) | 16'($urandom());
            vec_base_i = 4'($urandom());
            iei_n_i    = ($urandom() % 4) == 0;
            check_req_lines("R10 random");
            ack_cycle(1'($urandom()), (($urandom() % 3) == 0) ? 16'($urandom()) : 16'h0,
                      ($urandom() % 5) == 0, 1'b0);
            iei_n_i = 1'b0;
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule